// File: doc/BRIEF.md
# AFE Sample Bus Framer

This block sits on the modem side of the link to an analog front end. Everything runs on the 35.328 MHz converter master clock. The block makes a word-rate framing strobe from that clock: the strobe is high for one cycle in every four. It uses the strobe to send each 16-bit transmit sample across a 4-bit bus as four nibbles, most significant nibble first. The strobe is high while the leading nibble is on the bus. The same strobe also paces the serial control link that shares the front-end connection.

On the receive side, the converter samples at twice the bus rate. Each master-clock cycle therefore brings a 10-bit word holding two 5-bit sigma-delta samples. The block registers that word and presents the two samples on separate outputs, in time order, with a valid flag. Decimation, the converters and clock synthesis are handled elsewhere.

A transmit word is taken only in the one cycle per frame in which the ready output is high. If no word is offered in that cycle, the frame carries four zero nibbles.

Top module: `afe_bus_framer`

## Requirements
- R1: `wordClk` is high for exactly one clock cycle, and each rising edge comes four cycles after the previous one.
- R2: `txReady` is high exactly in the cycle immediately before each cycle in which `wordClk` is high, and low in every other cycle.
- R3: A word taken with `txValid` high while `txReady` is high leaves on `txNibble` over the next four cycles as bits [15:12], [11:8], [7:4] and [3:0], in that order. Bits [15:12] appear in the cycle in which `wordClk` is high.
- R4: If `txValid` is low in the `txReady` cycle, `txNibble` is zero for all four cycles of that frame.
- R5: Values on `txWord` and `txValid` in cycles where `txReady` is low have no effect on `txNibble`.
- R6: One cycle after a receive bus value is presented, `rxEarly` equals its bits [9:5] and `rxLate` equals its bits [4:0].
- R7: `rxValid` is low while reset is asserted and high in every cycle after the first clock edge with reset low.
- R8: Synchronous reset forces `wordClk` low, `txNibble` to zero and `txReady` low, and no word is accepted during it. After reset is released, the first `wordClk` high comes after the fourth clock edge, with `txReady` high after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 35.328 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| txWord | input | 16 | Transmit sample to be sent as nibbles |
| txValid | input | 1 | `txWord` holds a sample to send |
| txReady | output | 1 | Word is taken at the end of this cycle |
| wordClk | output | 1 | Word-rate framing strobe, one cycle in four |
| txNibble | output | 4 | Transmit nibble bus to the front end |
| rxBus | input | 10 | Receive bus carrying two packed 5-bit samples |
| rxEarly | output | 5 | Earlier sample of the previous bus cycle |
| rxLate | output | 5 | Later sample of the previous bus cycle |
| rxValid | output | 1 | Receive sample outputs are valid |

## Verification
The bench sends a different inverted word with `txValid` high in every non-ready cycle. A framer that latched words outside the ready slot would corrupt the following nibbles. Frames with `txValid` low must come out as zeros, so a stale shift register would be exposed. The all-ones, all-zeros and single-end-bit words make a reversed nibble order or a shift off by one frame show up. The bench also applies reset in the middle of a frame while a word is being offered. A design that still accepted that word, or that came out of reset in the wrong phase, would put the strobe or the first nibble in the wrong cycle.

// File: rtl/afe_framer_pkg.sv
package afe_framer_pkg;
  // Two converter samples share each bus cycle (ADC runs at twice the bus clock)
  localparam int RX_SAMPLES = 2;

  typedef struct packed {
    logic clear;   // synchronous reset of datapath state
    logic load;    // take a new word into the nibble shifter
    logic shift;   // advance the nibble shifter
    logic sample;  // capture the receive bus
  } framer_ctrl_t;
endpackage

// File: rtl/afe_framer_ctrl.sv
module afe_framer_ctrl
  import afe_framer_pkg::*;
#(
  parameter int NIBBLES = 4
) (
  input  logic         clk,
  input  logic         rst,
  output framer_ctrl_t ctrl,
  output logic         wordClk,
  output logic         txReady
);
  localparam int PH_W = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NIBBLES - 1);

  logic [PH_W-1:0] phaseQ;
  logic            wordClkQ;
  logic            lastPhase;

  assign lastPhase = (phaseQ == LAST_PH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ   <= '0;
      wordClkQ <= 1'b0;
    end else begin
      phaseQ   <= lastPhase ? '0 : phaseQ + 1'b1;
      wordClkQ <= lastPhase;
    end
  end

  always_comb begin
    ctrl.clear  = rst;
    ctrl.load   = !rst && lastPhase;
    ctrl.shift  = !rst && !lastPhase;
    ctrl.sample = !rst;
  end

  assign wordClk = wordClkQ;
  assign txReady = ctrl.load;
endmodule

// File: rtl/afe_framer_dp.sv
module afe_framer_dp
  import afe_framer_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 4,
  parameter int SAMP_W   = 5
) (
  input  logic                                  clk,
  input  framer_ctrl_t                          ctrl,
  input  logic [NIBBLE_W*NIBBLES-1:0]           txWord,
  input  logic                                  txValid,
  output logic [NIBBLE_W-1:0]                   txNibble,
  input  logic [SAMP_W*RX_SAMPLES-1:0]          rxBus,
  output logic [SAMP_W-1:0]                     rxEarly,
  output logic [SAMP_W-1:0]                     rxLate,
  output logic                                  rxValid
);
  localparam int WORD_W = NIBBLE_W * NIBBLES;
  localparam int RX_W   = SAMP_W * RX_SAMPLES;

  logic [WORD_W-1:0] shiftQ;
  logic [SAMP_W-1:0] sampQ [RX_SAMPLES];
  logic              rxValidQ;

  // Transmit: most significant nibble leads
  always_ff @(posedge clk) begin
    if (ctrl.clear)      shiftQ <= '0;
    else if (ctrl.load)  shiftQ <= txValid ? txWord : '0;
    else if (ctrl.shift) shiftQ <= shiftQ << NIBBLE_W;
  end

  assign txNibble = shiftQ[WORD_W-1 -: NIBBLE_W];

  // Receive: slot 0 is the top field and the earlier sample
  for (genvar s = 0; s < RX_SAMPLES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctrl.clear)       sampQ[s] <= '0;
      else if (ctrl.sample) sampQ[s] <= rxBus[RX_W-1-s*SAMP_W -: SAMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) rxValidQ <= 1'b0;
    else            rxValidQ <= ctrl.sample;
  end

  assign rxEarly = sampQ[0];
  assign rxLate  = sampQ[RX_SAMPLES-1];
  assign rxValid = rxValidQ;
endmodule

// File: rtl/afe_bus_framer.sv
module afe_bus_framer
  import afe_framer_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 4,
  parameter int SAMP_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NIBBLE_W*NIBBLES-1:0]   txWord,
  input  logic                          txValid,
  output logic                          txReady,
  output logic                          wordClk,
  output logic [NIBBLE_W-1:0]           txNibble,
  input  logic [SAMP_W*RX_SAMPLES-1:0]  rxBus,
  output logic [SAMP_W-1:0]             rxEarly,
  output logic [SAMP_W-1:0]             rxLate,
  output logic                          rxValid
);
  framer_ctrl_t ctrl;

  afe_framer_ctrl #(.NIBBLES(NIBBLES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .wordClk (wordClk),
    .txReady (txReady)
  );

  afe_framer_dp #(
    .NIBBLE_W(NIBBLE_W),
    .NIBBLES (NIBBLES),
    .SAMP_W  (SAMP_W)
  ) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .txWord   (txWord),
    .txValid  (txValid),
    .txNibble (txNibble),
    .rxBus    (rxBus),
    .rxEarly  (rxEarly),
    .rxLate   (rxLate),
    .rxValid  (rxValid)
  );
endmodule

// File: rtl/afe_bus_framer_chk.sv
module afe_bus_framer_chk
  import afe_framer_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  parameter int NIBBLES  = 4,
  parameter int SAMP_W   = 5
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NIBBLE_W*NIBBLES-1:0]   txWord,
  input logic                          txValid,
  input logic                          txReady,
  input logic                          wordClk,
  input logic [NIBBLE_W-1:0]           txNibble,
  input logic [SAMP_W*RX_SAMPLES-1:0]  rxBus,
  input logic [SAMP_W-1:0]             rxEarly,
  input logic [SAMP_W-1:0]             rxLate,
  input logic                          rxValid
);
  localparam int WORD_W = NIBBLE_W * NIBBLES;
  localparam int CNT_W  = $clog2(NIBBLES) + 1;

  logic [CNT_W-1:0] sinceQ;
  logic             seenQ;
  logic             rstD = 1'b0;

  always_ff @(posedge clk) begin
    rstD <= rst;
    if (rst) begin
      sinceQ <= '0;
      seenQ  <= 1'b0;
    end else begin
      seenQ  <= seenQ | wordClk;
      if (wordClk)                    sinceQ <= '0;
      else if (!(&sinceQ))            sinceQ <= sinceQ + 1'b1;
    end
  end

  AST_WCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wordClk |=> !wordClk); // R1
  AST_WCLK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (wordClk && seenQ) |-> (sinceQ == CNT_W'(NIBBLES - 1))); // R1
  AST_READY_BEFORE_WCLK: assert property (@(posedge clk) disable iff (rst)
    txReady |=> wordClk); // R2
  AST_WCLK_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    wordClk |-> $past(txReady)); // R2
  AST_TX_LEAD_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (wordClk && $past(txValid)) |-> (txNibble == $past(txWord[WORD_W-1 -: NIBBLE_W]))); // R3
  AST_TX_SECOND_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(wordClk) && $past(txValid, 2)) |->
      (txNibble == $past(txWord[WORD_W-NIBBLE_W-1 -: NIBBLE_W], 2))); // R3
  AST_TX_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wordClk && !$past(txValid)) |-> (txNibble == '0)); // R4
  AST_RX_SPLIT: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> ({rxEarly, rxLate} == $past(rxBus))); // R6

  always @(negedge clk) begin
    if (rstD) begin
      AST_RESET_QUIET: assert (!wordClk && txNibble == '0 && !rxValid); // R8
    end
  end
endmodule

bind afe_bus_framer afe_bus_framer_chk #(
  .NIBBLE_W(NIBBLE_W),
  .NIBBLES (NIBBLES),
  .SAMP_W  (SAMP_W)
) u_chk (.*);

// File: tb/tb_afe_bus_framer.sv
module tb_afe_bus_framer;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] txWord;
  logic        txValid;
  logic        txReady;
  logic        wordClk;
  logic [3:0]  txNibble;
  logic [9:0]  rxBus;
  logic [4:0]  rxEarly;
  logic [4:0]  rxLate;
  logic        rxValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [9:0] prevRx;

  always #5 clk = ~clk;

  afe_bus_framer dut (
    .clk(clk), .rst(rst), .txWord(txWord), .txValid(txValid), .txReady(txReady),
    .wordClk(wordClk), .txNibble(txNibble), .rxBus(rxBus), .rxEarly(rxEarly),
    .rxLate(rxLate), .rxValid(rxValid)
  );

  // {word, valid, rx seed}
  localparam int NV = 6;
  localparam logic [26:0] VECS [NV] = '{
    {16'h1234, 1'b1, 10'h3FF},
    {16'hFFFF, 1'b1, 10'h000},
    {16'hBEEF, 1'b0, 10'h2AA},
    {16'h8001, 1'b1, 10'h155},
    {16'h0000, 1'b1, 10'h3E0},
    {16'h5A3C, 1'b1, 10'h01F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at the negedge where reset has just been driven low
  task automatic align_after_reset();
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk);
      chk("R8 wordClk low before first frame", {31'd0, wordClk}, 32'd0);
      chk("R8 txNibble zero before first frame", {28'd0, txNibble}, 32'd0);
      chk("R7 rxValid after reset release", {31'd0, rxValid}, 32'd1);
      chk("R8 txReady timing after reset", {31'd0, txReady}, (e == 3) ? 32'd1 : 32'd0);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input logic v, input logic [9:0] rxSeed);
    chk("R2 txReady before frame", {31'd0, txReady}, 32'd1);
    txWord  = w;
    txValid = v;
    rxBus   = rxSeed;
    prevRx  = rxSeed;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 wordClk position", {31'd0, wordClk}, (k == 0) ? 32'd1 : 32'd0);
      chk(v ? "R3 nibble order" : "R4 idle frame zero", {28'd0, txNibble},
          v ? {28'd0, w[15-4*k -: 4]} : 32'd0);
      if (k < 3) chk("R2 txReady low mid-frame", {31'd0, txReady}, 32'd0);
      chk("R6 rxEarly", {27'd0, rxEarly}, {27'd0, prevRx[9:5]});
      chk("R6 rxLate", {27'd0, rxLate}, {27'd0, prevRx[4:0]});
      chk("R7 rxValid", {31'd0, rxValid}, 32'd1);
      rxBus  = rxSeed ^ 10'(k * 37 + 1);
      prevRx = rxBus;
      if (k < 3) begin
        // R5: junk offered outside the ready cycle must not reach the bus
        txWord  = ~w;
        txValid = 1'b1;
      end
    end
  endtask

  initial begin
    rst = 1'b1; txWord = '0; txValid = 1'b0; rxBus = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset wordClk", {31'd0, wordClk}, 32'd0);
    chk("R8 reset txNibble", {28'd0, txNibble}, 32'd0);
    chk("R8 reset txReady", {31'd0, txReady}, 32'd0);
    chk("R7 reset rxValid", {31'd0, rxValid}, 32'd0);
    rst = 1'b0;
    align_after_reset();

    for (int i = 0; i < NV; i++) begin
      send_frame(VECS[i][26:11], VECS[i][10], VECS[i][9:0]);
    end

    // Reset in mid-stream while a word is offered in the ready slot
    txWord = 16'hF00D; txValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R8 no accept during reset wordClk", {31'd0, wordClk}, 32'd0);
    chk("R8 no accept during reset txNibble", {28'd0, txNibble}, 32'd0);
    chk("R8 txReady low in reset", {31'd0, txReady}, 32'd0);
    chk("R7 rxValid low in reset", {31'd0, rxValid}, 32'd0);
    @(negedge clk);
    txValid = 1'b0;
    rst = 1'b0;
    align_after_reset();
    send_frame(16'hC3A5, 1'b1, 10'h2D4);
    send_frame(16'h7E81, 1'b0, 10'h0F0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule